// File: doc/BRIEF.md
# I2C Controller Address Phase Sequencer

This block runs the address phase of an I2C controller transaction. Software programs a target address, a transfer direction, a 7-bit/10-bit mode select and a header-only option for 10-bit reads, then raises a start request. The sequencer copies these settings into its own register when it accepts the request. It then sends an ordered list of bus actions to a downstream bit engine: a START condition, address bytes, a repeated START where one is needed, and an ACK wait after every address byte.

The actions leave on a valid/ready stream. A command stays on `cmd_valid`, `cmd_kind` and `cmd_data` without change until the bit engine accepts it with `cmd_ready`. The stream has no skid buffer, so back-pressure stalls the sequencer in place. When the engine accepts an address byte, it later returns a one-cycle response carrying the sampled ACK bit. A START or repeated START needs no response. The phase ends with a one-cycle `done` pulse after the last byte is ACKed, or a one-cycle `nack` pulse as soon as any byte is NACKed.

The 10-bit header byte is `11110`, then address bits 9:8, then the direction bit in the least significant position. In the 10-bit read case the target must first be addressed in write direction before the read header is sent, unless the header-only option selects the short form.

Top module: `i2c_addr_seq`

## Requirements
- R1: In 7-bit mode the sequence is START (`cmd_kind`=0), then one byte (`cmd_kind`=2) equal to address bits 7:1 followed by the direction bit as bit 0. Address bits 9, 8 and 0 have no effect, and the header-only option has no effect.
- R2: In 10-bit mode with direction 0 the sequence is START, then header `{11110, addr[9:8], 0}`, then `addr[7:0]`. The header-only option has no effect.
- R3: In 10-bit mode with direction 1 and header-only clear the sequence is START, `{11110, addr[9:8], 0}`, `addr[7:0]`, repeated START (`cmd_kind`=1), then `{11110, addr[9:8], 1}`.
- R4: In 10-bit mode with direction 1 and header-only set the sequence is START, then `{11110, addr[9:8], 1}` only.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind` and `cmd_data` hold their values into the next cycle. A command is consumed only in a cycle where both are high.
- R6: After an address byte is accepted, `cmd_valid` stays low until `rsp_valid` is seen. `rsp_valid` is ignored when no byte is awaiting its ACK.
- R7: A response with `rsp_nack`=1 ends the phase. `nack` is high for exactly the next cycle, `busy` falls in that cycle, and no further command of that phase is presented.
- R8: An ACK on the last byte of the sequence gives a `done` pulse of exactly one cycle in the next cycle, with `busy` low from that cycle on. `done` and `nack` are never high together.
- R9: Address, direction, mode and header-only inputs are sampled in the cycle the start request is accepted. Later changes do not alter the running phase.
- R10: A start request is accepted only while `busy` is low. `start_req` has no effect while busy, and a start request in the `done` or `nack` cycle is accepted.
- R11: After reset `busy`, `done`, `nack` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to begin an address phase |
| tgt_addr | input | 10 | Target address (7-bit mode uses bits 7:1) |
| dir_rd | input | 1 | Direction: 0 write, 1 read |
| addr10 | input | 1 | 1 selects 10-bit addressing |
| hdr_only_rd | input | 1 | 10-bit read: send only the read header |
| busy | output | 1 | Address phase in progress |
| done | output | 1 | One-cycle pulse: phase completed with all ACKs |
| nack | output | 1 | One-cycle pulse: phase aborted on a NACK |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Bit engine accepts the command |
| cmd_kind | output | 2 | 0 START, 1 repeated START, 2 address byte |
| cmd_data | output | 8 | Byte to send when `cmd_kind`=2, else 0 |
| rsp_valid | input | 1 | ACK sample for the outstanding byte is available |
| rsp_nack | input | 1 | 1 when that byte was NACKed |

## Verification
The bench covers every combination of mode, direction and header-only setting. It uses address values whose ignored bits are set, so a design that takes the 7-bit byte from bits 6:0 or adds bits 9/8 sends the wrong byte. It injects a NACK at each byte position of each sequence. A design that does not stop on an early NACK, or that pulses `done` as well, sends an extra command or raises both flags. Long stretches of `cmd_ready` low and delayed ACK responses expose a sequencer that skips ahead or drops a held command. Inputs that change mid-phase and start requests repeated while busy expose settings that are not latched and restarts that break a running phase.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int ADDR_W     = 10;
  localparam int BYTE_W     = 8;
  localparam int STEP_MAX   = 5;
  localparam int STEP_IDX_W = $clog2(STEP_MAX);
  localparam int HI_W       = ADDR_W - BYTE_W;
  localparam int PREFIX_W   = BYTE_W - HI_W - 1;
  localparam logic [PREFIX_W-1:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    CMD_START   = 2'd0,
    CMD_RESTART = 2'd1,
    CMD_BYTE    = 2'd2
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e         kind;
    logic [BYTE_W-1:0] data;
  } step_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              ten;
    logic              hdr_only;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_ACK   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/i2c_addr_cfg_hold.sv
module i2c_addr_cfg_hold
  import i2c_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= '0;
    else if (capture) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/i2c_addr_plan.sv
module i2c_addr_plan
  import i2c_addr_pkg::*;
(
  input  cfg_t                         cfg,
  output step_t [STEP_MAX-1:0]         steps,
  output logic  [STEP_IDX_W-1:0]       last_idx
);
  logic [BYTE_W-1:0] hdr_wr;
  logic [BYTE_W-1:0] hdr_rd;
  logic [BYTE_W-1:0] low_byte;
  logic [BYTE_W-1:0] short_byte;

  always_comb begin
    hdr_wr     = {HDR_PREFIX, cfg.addr[ADDR_W-1:BYTE_W], 1'b0};
    hdr_rd     = {HDR_PREFIX, cfg.addr[ADDR_W-1:BYTE_W], 1'b1};
    low_byte   = cfg.addr[BYTE_W-1:0];
    short_byte = {cfg.addr[BYTE_W-1:1], cfg.rd};
  end

  always_comb begin
    for (int i = 0; i < STEP_MAX; i++) begin
      steps[i].kind = CMD_START;
      steps[i].data = '0;
    end
    last_idx = STEP_IDX_W'(1);
    if (!cfg.ten) begin
      steps[1].kind = CMD_BYTE;
      steps[1].data = short_byte;
    end else if (cfg.rd && cfg.hdr_only) begin
      steps[1].kind = CMD_BYTE;
      steps[1].data = hdr_rd;
    end else begin
      steps[1].kind = CMD_BYTE;
      steps[1].data = hdr_wr;
      steps[2].kind = CMD_BYTE;
      steps[2].data = low_byte;
      last_idx      = STEP_IDX_W'(2);
      if (cfg.rd) begin
        steps[3].kind = CMD_RESTART;
        steps[4].kind = CMD_BYTE;
        steps[4].data = hdr_rd;
        last_idx      = STEP_IDX_W'(4);
      end
    end
  end
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_addr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_req,
  input  step_t [STEP_MAX-1:0]       steps,
  input  logic  [STEP_IDX_W-1:0]     last_idx,
  output logic                       accept,
  output logic                       busy,
  output logic                       done,
  output logic                       nack,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic  [1:0]                cmd_kind,
  output logic  [BYTE_W-1:0]         cmd_data,
  input  logic                       rsp_valid,
  input  logic                       rsp_nack
);
  seq_state_e            state;
  logic [STEP_IDX_W-1:0] idx;
  step_t                 cur;
  logic [STEP_IDX_W-1:0] idx_next;

  always_comb begin
    cur      = steps[idx];
    idx_next = idx + STEP_IDX_W'(1);
    accept   = (state == ST_IDLE) && start_req;
    busy     = (state != ST_IDLE);
    cmd_valid = (state == ST_ISSUE);
    cmd_kind  = cur.kind;
    cmd_data  = cur.data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
      nack  <= 1'b0;
    end else begin
      done <= 1'b0;
      nack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_req) begin
            state <= ST_ISSUE;
            idx   <= '0;
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            if (cur.kind == CMD_BYTE) state <= ST_ACK;
            else                      idx   <= idx_next;
          end
        end
        ST_ACK: begin
          if (rsp_valid) begin
            if (rsp_nack) begin
              nack  <= 1'b1;
              state <= ST_IDLE;
            end else if (idx == last_idx) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              idx   <= idx_next;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              dir_rd,
  input  logic              addr10,
  input  logic              hdr_only_rd,
  output logic              busy,
  output logic              done,
  output logic              nack,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [BYTE_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_nack
);
  cfg_t                   cfg_in;
  cfg_t                   cfg_q;
  logic                   accept;
  step_t [STEP_MAX-1:0]   steps;
  logic [STEP_IDX_W-1:0]  last_idx;

  always_comb begin
    cfg_in.addr     = tgt_addr;
    cfg_in.rd       = dir_rd;
    cfg_in.ten      = addr10;
    cfg_in.hdr_only = hdr_only_rd;
  end

  i2c_addr_cfg_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q)
  );

  i2c_addr_plan u_plan (
    .cfg      (cfg_q),
    .steps    (steps),
    .last_idx (last_idx)
  );

  i2c_addr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .steps     (steps),
    .last_idx  (last_idx),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .nack      (nack),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_nack  (rsp_nack)
  );
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       nack,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_kind,
  input logic [7:0] cmd_data
);
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_data))); // R5
  AST_OPENS_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_valid && cmd_kind == 2'd0)); // R1
  AST_BYTE_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'd2) |=> !cmd_valid); // R6
  AST_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> (!busy && !cmd_valid)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || nack)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && nack)); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid); // R10
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .nack      (nack),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .cmd_data  (cmd_data)
);

// File: tb/i2c_addr_seq_tb_top.sv
module i2c_addr_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic [9:0] tgt_addr = '0;
  logic       dir_rd = 1'b0, addr10 = 1'b0, hdr_only_rd = 1'b0;
  logic       busy, done, nack, cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [1:0] cmd_kind;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0, rsp_nack = 1'b0;

  always #2 clk = ~clk;

  i2c_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .tgt_addr(tgt_addr),
    .dir_rd(dir_rd), .addr10(addr10), .hdr_only_rd(hdr_only_rd),
    .busy(busy), .done(done), .nack(nack), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  bit run_en = 0;
  string cur_req = "R11";

  // scenario controls
  int s_addr, s_dir, s_m10, s_ho, s_stall, s_delay, s_nack_at, s_scr, s_spam;
  bit want_start = 0;

  // reference model
  int qk[$], qd[$];
  bit m_busy = 0, m_wait = 0, m_done = 0, m_nack = 0;
  int byte_no = 0, wcnt = 0, cyc = 0, done_cnt = 0, nack_cnt = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_q(int a, int d, int m, int h);
    int hdr;
    qk.delete(); qd.delete();
    qk.push_back(0); qd.push_back(0);
    if (m == 0) begin
      qk.push_back(2); qd.push_back(((a >> 1) & 127) * 2 + d);
    end else begin
      hdr = 240 + ((a >> 8) & 3) * 2;
      if (d != 0 && h != 0) begin
        qk.push_back(2); qd.push_back(hdr + 1);
      end else begin
        qk.push_back(2); qd.push_back(hdr);
        qk.push_back(2); qd.push_back(a & 255);
        if (d != 0) begin
          qk.push_back(1); qd.push_back(0);
          qk.push_back(2); qd.push_back(hdr + 1);
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (run_en) begin
      bit ev;
      int k;
      cyc++;
      ev = m_busy && !m_wait;
      chk(busy == m_busy, cur_req, "busy", busy, m_busy);
      chk(cmd_valid == ev, cur_req, "cmd_valid", cmd_valid, ev);
      if (ev && cmd_valid) begin
        chk(int'(cmd_kind) == qk[0], cur_req, "cmd_kind", cmd_kind, qk[0]);
        chk(int'(cmd_data) == qd[0], cur_req, "cmd_data", cmd_data, qd[0]);
      end
      chk(done == m_done, cur_req, "done", done, m_done);
      chk(nack == m_nack, cur_req, "nack", nack, m_nack);
      if (done) done_cnt++;
      if (nack) nack_cnt++;
      // drive inputs for the coming edge
      start_req = want_start || (s_spam != 0 && m_busy);
      if (s_scr != 0 && m_busy) begin
        tgt_addr = 10'($urandom); dir_rd = 1'($urandom);
        addr10 = 1'($urandom); hdr_only_rd = 1'($urandom);
      end else begin
        tgt_addr = 10'(s_addr); dir_rd = s_dir[0];
        addr10 = s_m10[0]; hdr_only_rd = s_ho[0];
      end
      cmd_ready = (s_stall != 0) ? (cyc % 4 == 3) : 1'b1;
      if (m_wait) begin
        wcnt++;
        rsp_valid = (wcnt > s_delay);
      end else begin
        wcnt = 0;
        rsp_valid = (s_stall != 0) && (cyc % 2 == 0); // stray response, R6
      end
      rsp_nack = rsp_valid && (byte_no - 1 == s_nack_at);
      // advance model
      m_done = 0; m_nack = 0;
      if (!m_busy) begin
        if (start_req) begin
          build_q(s_addr, s_dir, s_m10, s_ho);
          m_busy = 1; m_wait = 0; byte_no = 0; want_start = 0;
        end
      end else if (!m_wait) begin
        if (cmd_ready) begin
          k = qk.pop_front();
          void'(qd.pop_front());
          if (k == 2) begin m_wait = 1; byte_no++; end
        end
      end else if (rsp_valid) begin
        m_wait = 0;
        if (rsp_nack) begin
          m_nack = 1; m_busy = 0; qk.delete(); qd.delete();
        end else if (qk.size() == 0) begin
          m_done = 1; m_busy = 0;
        end
      end
    end
  end

  task automatic run(int a, int d, int m, int h, int st, int dl, int nk,
                     int sc, int sp, string rq);
    int nb;
    bit exp_done;
    s_addr = a; s_dir = d; s_m10 = m; s_ho = h; s_stall = st; s_delay = dl;
    s_nack_at = nk; s_scr = sc; s_spam = sp; cur_req = rq;
    done_cnt = 0; nack_cnt = 0;
    want_start = 1;
    @(posedge clk);
    while (want_start || m_busy) @(posedge clk);
    s_spam = 0; s_scr = 0; s_stall = 0;
    repeat (3) @(posedge clk);
    nb = (m == 0) ? 1 : ((d == 0) ? 2 : ((h != 0) ? 1 : 3));
    exp_done = (nk < 0) || (nk >= nb);
    chk(done_cnt == int'(exp_done), "R8", "done pulses", done_cnt, exp_done);
    chk(nack_cnt == int'(!exp_done), "R7", "nack pulses", nack_cnt, !exp_done);
  endtask

  initial begin
    s_addr = 0; s_dir = 0; s_m10 = 0; s_ho = 0; s_stall = 0; s_delay = 0;
    s_nack_at = -1; s_scr = 0; s_spam = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !nack && !cmd_valid, "R11", "reset outputs",
        {busy, done, nack, cmd_valid}, 0);
    run_en = 1;
    @(posedge clk);
    // R1: 7-bit, ignored bits 9, 8, 0 set; header-only has no effect
    run(10'h3A5, 0, 0, 0, 0, 0, -1, 0, 0, "R1");
    run(10'h3A5, 1, 0, 1, 0, 1, -1, 0, 0, "R1");
    run(10'h05A, 1, 0, 0, 0, 0, -1, 0, 0, "R1");
    // R2: 10-bit write, header-only ignored
    run(10'h2C3, 0, 1, 0, 0, 0, -1, 0, 0, "R2");
    run(10'h1FF, 0, 1, 1, 0, 2, -1, 0, 0, "R2");
    // R3: full 10-bit read
    run(10'h3E7, 1, 1, 0, 0, 0, -1, 0, 0, "R3");
    run(10'h100, 1, 1, 0, 0, 1, -1, 0, 0, "R3");
    // R4: header-only 10-bit read
    run(10'h2AA, 1, 1, 1, 0, 0, -1, 0, 0, "R4");
    // R5 back-pressure, R6 delayed ACK and stray responses
    run(10'h355, 1, 1, 0, 1, 0, -1, 0, 0, "R5");
    run(10'h0F1, 1, 0, 0, 1, 3, -1, 0, 0, "R5");
    run(10'h355, 1, 1, 0, 0, 5, -1, 0, 0, "R6");
    run(10'h2C3, 0, 1, 0, 1, 4, -1, 0, 0, "R6");
    // R7: NACK at each byte position of every sequence shape
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int h = 0; h < 2; h++)
          for (int nk = 0; nk < 3; nk++)
            run(10'h2B6 + nk, d, m, h, nk % 2, nk, nk, 0, 0, "R7");
    // R8: done timing
    run(10'h011, 0, 1, 0, 0, 0, -1, 0, 0, "R8");
    // R9: inputs scrambled while busy
    run(10'h1C9, 1, 1, 0, 0, 1, -1, 1, 0, "R9");
    run(10'h0B4, 0, 0, 0, 1, 0, -1, 1, 0, "R9");
    // R10: start request held high while busy
    run(10'h3C3, 1, 1, 0, 0, 2, -1, 0, 1, "R10");
    run(10'h3C3, 1, 1, 0, 0, 0, 1, 0, 1, "R10");
    // R10: back-to-back start accepted in the done cycle
    cur_req = "R10";
    s_spam = 0; want_start = 1;
    s_addr = 10'h123; s_dir = 0; s_m10 = 0; s_ho = 0; s_delay = 0; s_nack_at = -1;
    @(posedge clk);
    while (want_start || m_busy) @(posedge clk);
    want_start = 1;
    while (!done) @(posedge clk);
    @(posedge clk);
    while (want_start || m_busy) @(posedge clk);
    repeat (3) @(posedge clk);
    run_en = 0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule